// File: doc/BRIEF.md
# Key-Locked Memory Controller Register File

This block holds the software-visible configuration and status words of a DRAM controller. A single 32-bit register port with word addresses, a write enable and a combinational read path serves every register. Writes are filtered by a protection word at word address 0. That word holds one of three lock states: open, soft-locked or hard-locked. A specific key value opens the register file. A second key seals it until the next reset. Any other value written to the protection word soft-locks it.

A fixed set of status, interrupt, test-result and per-port monitor words ignores the lock and always accepts writes. The main configuration word keeps a set of read-only bits at zero. Its page-matching bit is always set, and its size field always reflects the RAM size code presented at the `ram_size` input. The main status word never reports the PHY as busy. A reset-time strap input chooses whether the block leaves reset open or soft-locked. Every write that the lock drops produces a one-cycle `write_blocked` pulse.

Top module: `memctl_cfg_regfile`

## Requirements
- R1: During and after reset, every word reads 0 with two exceptions. The protection word (word 0) reads 1 when `strap_unlock` is high and 0 when it is low. The main configuration word (word 4) reads 0x20 | (ram_size << 2).
- R2: Writing 0x1688A8A8 to word 0 in the open or soft-locked state makes word 0 read 0x00000001 (open). In the open state, protected words accept writes.
- R3: Writing 0xDEADDEAD to word 0 in the open or soft-locked state makes word 0 read 0x00000002 (hard-locked). From then until reset, every protected write is dropped, including writes to word 0.
- R4: Writing any other value to word 0 in the open or soft-locked state makes it read 0x00000000 (soft-locked). In this state, protected writes to words other than 0 are dropped, while writes to word 0 are still decoded.
- R5: The following words accept writes in every lock state: 1, 2, 3, 6, 7, 0x1E, 0x1F, 0x25, 0x35 to 0x39, 0x3D, 0x3E and 0x43. The monitor words 0x90 + 0x20·p + k, for p from 0 to 5 and k from 0 to 2, also accept writes in every state.
- R6: An accepted write to word 4 stores the data with two changes. The bits in mask 0xFFFF2082 are cleared and bit 5 is set. Bits 4:2 are replaced by `ram_size`, where codes 0 to 5 denote 256 MiB, 512 MiB, 1 GiB, 2 GiB, 4 GiB and 8 GiB.
- R7: Bit 0 of the main status word (word 6) is the PHY busy flag. It reads 0 after every write, and the other bits store as written.
- R8: `write_blocked` goes high for exactly the one cycle after a clock edge at which a write was dropped. It is low after accepted writes.
- R9: A protected word outside the special cases (for example word 0x20) stores the full 32-bit data when open and keeps its value when a write to it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_unlock | input | 1 | Strap: leave reset in the open state |
| ram_size | input | 3 | RAM size code placed in configuration bits 4:2 |
| addr | input | ADDR_W | Word address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| write_blocked | output | 1 | One-cycle pulse after a dropped write |

## Verification
The bench builds the block with its defaults. A 9-bit word address covers the top monitor word 0x132, and six monitor ports reach that last port's words. Running two resets with different strap and size values brings both reset lock states and two encodings of the size field within reach. Directed sequences take the lock through open, soft and hard, and probe a protected word, the configuration and status words, and several always-writable words in each state.

// File: rtl/memctl_regs_pkg.sv
package memctl_regs_pkg;

    typedef enum logic [1:0] {
        LK_SOFT = 2'd0,
        LK_OPEN = 2'd1,
        LK_HARD = 2'd2
    } lock_e;

    typedef struct packed {
        logic prot;
        logic conf;
        logic stat;
        logic open;
    } addr_cls_t;

    localparam logic [31:0] KEY_OPEN     = 32'h1688_A8A8;
    localparam logic [31:0] KEY_HARD     = 32'hDEAD_DEAD;
    localparam logic [31:0] CONF_RO_MASK = 32'hFFFF_2082;
    localparam int          W_PROT        = 0;
    localparam int          W_CONF        = 4;
    localparam int          W_STAT        = 6;
    localparam int          CONF_PAGE_BIT = 5;
    localparam int          CONF_SIZE_LSB = 2;
    localparam int          STAT_BUSY_BIT = 0;

    function automatic lock_e key_decode(input logic [31:0] d);
        if (d == KEY_OPEN)      return LK_OPEN;
        else if (d == KEY_HARD) return LK_HARD;
        else                    return LK_SOFT;
    endfunction

    function automatic logic [31:0] conf_merge(input logic [31:0] d, input logic [2:0] sz);
        logic [31:0] v;
        v = d & ~CONF_RO_MASK;
        v[CONF_SIZE_LSB +: 3] = sz;
        v[CONF_PAGE_BIT] = 1'b1;
        return v;
    endfunction

    function automatic logic fixed_open(input logic [31:0] w);
        case (w)
            32'h01, 32'h02, 32'h03, 32'h06, 32'h07, 32'h1E, 32'h1F, 32'h25,
            32'h35, 32'h36, 32'h37, 32'h38, 32'h39, 32'h3D, 32'h3E, 32'h43:
                return 1'b1;
            default:
                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/memctl_addr_class.sv
module memctl_addr_class
    import memctl_regs_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int MON_PORTS    = 6,
    parameter int MON_BASE_W   = 32'h90,
    parameter int MON_STRIDE_W = 32'h20,
    parameter int MON_WORDS    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_cls_t         cls
);
    logic [31:0]          a32;
    logic [MON_PORTS-1:0] mon_hit;

    assign a32 = 32'(addr);

    for (genvar p = 0; p < MON_PORTS; p++) begin : g_mon
        localparam logic [31:0] LO = 32'(MON_BASE_W + p * MON_STRIDE_W);
        localparam logic [31:0] HI = 32'(MON_BASE_W + p * MON_STRIDE_W + MON_WORDS);
        assign mon_hit[p] = (a32 >= LO) && (a32 < HI);
    end

    always_comb begin
        cls.prot = (a32 == 32'(W_PROT));
        cls.conf = (a32 == 32'(W_CONF));
        cls.stat = (a32 == 32'(W_STAT));
        cls.open = fixed_open(a32) || (|mon_hit);
    end
endmodule

// File: rtl/memctl_key_lock.sv
module memctl_key_lock
    import memctl_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_unlock,
    input  logic        wr_en,
    input  logic        sel_prot,
    input  logic [31:0] wr_data,
    output lock_e       state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= strap_unlock ? LK_OPEN : LK_SOFT;
        else if (wr_en && sel_prot && state != LK_HARD)
            state <= key_decode(wr_data);
    end

    // R3: the hard lock is left only through reset
    assert_hard_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (state == LK_HARD) |=> (state == LK_HARD));

    // R4: leaving the soft lock needs a write to the protection word
    assert_soft_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (state == LK_SOFT && !(wr_en && sel_prot)) |=> (state == LK_SOFT));
endmodule

// File: rtl/memctl_reg_store.sv
module memctl_reg_store
    import memctl_regs_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       conf_init,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            mem[W_CONF] <= conf_init;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/memctl_cfg_regfile.sv
module memctl_cfg_regfile
    import memctl_regs_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int MON_PORTS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_unlock,
    input  logic [2:0]        ram_size,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              write_blocked
);
    addr_cls_t   cls;
    lock_e       state;
    logic        allow;
    logic        store_we;
    logic [31:0] store_wdata;
    logic [31:0] store_rdata;

    memctl_addr_class #(.ADDR_W(ADDR_W), .MON_PORTS(MON_PORTS)) u_class (
        .addr (addr),
        .cls  (cls)
    );

    memctl_key_lock u_lock (
        .clk          (clk),
        .rst          (rst),
        .strap_unlock (strap_unlock),
        .wr_en        (wr_en),
        .sel_prot     (cls.prot),
        .wr_data      (wr_data),
        .state        (state)
    );

    // open list bypasses the lock; soft lock still lets the key word through
    assign allow    = cls.open || (state == LK_OPEN) || (cls.prot && state == LK_SOFT);
    assign store_we = wr_en && allow && !cls.prot;

    always_comb begin
        store_wdata = wr_data;
        if (cls.conf) store_wdata = conf_merge(wr_data, ram_size);
        if (cls.stat) store_wdata[STAT_BUSY_BIT] = 1'b0;
    end

    memctl_reg_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .conf_init (conf_merge('0, ram_size)),
        .we        (store_we),
        .addr      (addr),
        .wdata     (store_wdata),
        .rdata     (store_rdata)
    );

    assign rd_data = cls.prot ? {30'd0, state} : store_rdata;

    always_ff @(posedge clk) begin
        if (rst) write_blocked <= 1'b0;
        else     write_blocked <= wr_en && !allow;
    end

    // R6: configuration word never shows read-only bits and always shows page matching
    assert_conf_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        cls.conf |-> (rd_data[CONF_PAGE_BIT] && (rd_data & CONF_RO_MASK) == 32'd0));

    // R7: PHY busy flag never reads as set
    assert_busy_clear_R7: assert property (@(posedge clk) disable iff (rst)
        cls.stat |-> !rd_data[STAT_BUSY_BIT]);

    // R8: every dropped write is flagged next cycle
    assert_drop_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !allow) |=> write_blocked);

    // R8: no flag without a write in the cycle before
    assert_flag_cause_R8: assert property (@(posedge clk) disable iff (rst)
        write_blocked |-> $past(wr_en));

    // R5: always-writable words are never dropped
    assert_open_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cls.open) |=> !write_blocked);
endmodule

// File: tb/tb_memctl_cfg_regfile.sv
module tb_memctl_cfg_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_unlock = 1'b0;
    logic [2:0]  ram_size = 3'd3;
    logic [8:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        write_blocked;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    memctl_cfg_regfile dut (
        .clk (clk), .rst (rst), .strap_unlock (strap_unlock), .ram_size (ram_size),
        .addr (addr), .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_data),
        .write_blocked (write_blocked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap, input logic [2:0] sz);
        @(negedge clk);
        rst = 1'b1; strap_unlock = strap; ram_size = sz; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input string tag, input logic [8:0] a, input logic [31:0] d,
                      input logic exp_blk);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk({tag, " blocked flag (R8)"}, 32'(write_blocked), 32'(exp_blk));
    endtask

    task automatic rd(input string tag, input logic [8:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic t_reset_soft;
        do_reset(1'b0, 3'd3);
        rd("R1 prot after reset", 9'h000, 32'h0);
        rd("R1 conf after reset", 9'h004, 32'h0000_002C);
        rd("R1 plain word after reset", 9'h020, 32'h0);
        chk("R8 idle flag", 32'(write_blocked), 32'h0);
    endtask

    task automatic t_soft_then_open;
        wr("R4 conf in soft", 9'h004, 32'hFFFF_FFFF, 1'b1);
        rd("R4 conf unchanged", 9'h004, 32'h0000_002C);
        wr("R2 key", 9'h000, 32'h1688_A8A8, 1'b0);
        rd("R2 prot open", 9'h000, 32'h1);
    endtask

    task automatic t_open_writes;
        wr("R6 conf all ones", 9'h004, 32'hFFFF_FFFF, 1'b0);
        rd("R6 conf masked", 9'h004, 32'h0000_DF6D);
        wr("R6 conf zero", 9'h004, 32'h0, 1'b0);
        rd("R6 conf forced", 9'h004, 32'h0000_002C);
        wr("R7 status", 9'h006, 32'h0000_FFFF, 1'b0);
        rd("R7 busy cleared", 9'h006, 32'h0000_FFFE);
        wr("R9 plain word", 9'h020, 32'hA5A5_5A5A, 1'b0);
        rd("R9 plain readback", 9'h020, 32'hA5A5_5A5A);
    endtask

    task automatic t_soft_lock;
        wr("R4 other value", 9'h000, 32'h0000_1234, 1'b0);
        rd("R4 prot soft", 9'h000, 32'h0);
        wr("R4 plain in soft", 9'h020, 32'h1111_1111, 1'b1);
        rd("R9 kept after drop", 9'h020, 32'hA5A5_5A5A);
        wr("R5 phy status in soft", 9'h03E, 32'h0000_00C3, 1'b0);
        rd("R5 phy status readback", 9'h03E, 32'h0000_00C3);
        wr("R5 port5 monitor", 9'h132, 32'hCAFE_0005, 1'b0);
        rd("R5 port5 monitor readback", 9'h132, 32'hCAFE_0005);
        wr("R5 past monitor", 9'h133, 32'h5, 1'b1);
        wr("R4 key in soft", 9'h000, 32'h1688_A8A8, 1'b0);
        rd("R2 reopen", 9'h000, 32'h1);
    endtask

    task automatic t_hard_lock;
        wr("R3 hard key", 9'h000, 32'hDEAD_DEAD, 1'b0);
        rd("R3 prot hard", 9'h000, 32'h2);
        wr("R3 key in hard", 9'h000, 32'h1688_A8A8, 1'b1);
        rd("R3 still hard", 9'h000, 32'h2);
        wr("R3 conf in hard", 9'h004, 32'h0000_0100, 1'b1);
        rd("R3 conf kept", 9'h004, 32'h0000_002C);
        wr("R5 region lock in hard", 9'h025, 32'h7777_0000, 1'b0);
        rd("R5 region lock readback", 9'h025, 32'h7777_0000);
        wr("R5 test fail in hard", 9'h035, 32'h0BAD_F00D, 1'b0);
        rd("R5 test fail readback", 9'h035, 32'h0BAD_F00D);
        wr("R7 status in hard", 9'h006, 32'h0000_0001, 1'b0);
        rd("R7 busy cleared in hard", 9'h006, 32'h0);
    endtask

    task automatic t_reset_strap;
        do_reset(1'b1, 3'd5);
        rd("R1 prot strap open", 9'h000, 32'h1);
        rd("R1 conf size 5", 9'h004, 32'h0000_0034);
        rd("R1 plain cleared", 9'h020, 32'h0);
        rd("R1 open word cleared", 9'h025, 32'h0);
        wr("R6 conf size 5", 9'h004, 32'h0000_0110, 1'b0);
        rd("R6 conf size 5 readback", 9'h004, 32'h0000_0134);
    endtask

    initial begin
        fork
            begin
                t_reset_soft();
                t_soft_then_open();
                t_open_writes();
                t_soft_lock();
                t_hard_lock();
                t_reset_strap();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule